// File: doc/BRIEF.md
# Maskable Interrupt Status Hub

This block gathers five interrupt causes for a display transmitter wrapper and reduces them to one interrupt line. The causes are a rising edge on the core's interrupt level, hot-plug rise, hot-plug fall, nonce refresh rise and a random-number error. Each cause sets a sticky status bit. The status bits are ANDed with an active-high enable mask and then ORed into `irqOut`.

Software reaches the block through three word registers on a simple strobe interface:

- **Mask (address 0):** holds the enable bit for each cause.
- **Status (address 1):** reads back the sticky bits and the live core level in the top bit. A 1 written to a bit sets that bit, so software can raise an interrupt for test.
- **Clear (address 2):** a 1 written to a bit drops the matching status bit.

Bit positions are the same in all three registers: 0 core, 1 hot-plug rise, 2 hot-plug fall, 3 nonce refresh rise, 4 random-number error.

Top module: `irq_hub`

## Requirements
- R1: After a synchronous reset the mask and all status bits are 0, `irqOut` is 0 and `rdData` is 0.
- R2: `irqOut` is 1 exactly when some status bit and its mask bit are both 1. It follows register state combinationally, so it changes right after the clock edge that updates the registers.
- R3: A write to address 0 stores `wrData[4:0]` as the mask. In the mask, 1 enables a cause. A read of address 0 returns the mask in bits [4:0] and 0 in every other bit.
- R4: A write to address 2 clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged. Reads of address 2 return 0.
- R5: A write to address 1 sets each status bit whose data bit is 1. Data bits that are 0 have no effect.
- R6: Status bit 0 is set on the clock edge where `coreLevel` is first seen at 1 after having been 0 (0 is assumed before reset ends). A level that stays high does not set the bit again after a clear.
- R7: A 1 on `evtPulse[k]` (k = 1..4) at a clock edge sets status bit k. Without an event or a set write, a status bit never goes from 0 to 1.
- R8: When a hardware event and a clear of the same bit occur at the same edge, the event wins and the bit stays 1.
- R9: In a status read, bit 31 carries the live `coreLevel` sampled at the read edge, not a latched value.
- R10: `rdData` is registered. It updates at the edge where `rdEn` is 1 and holds otherwise. Address 3 reads as 0, and writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 2 | Read address |
| rdData | output | 32 | Registered read data |
| coreLevel | input | 1 | Core interrupt level (edge detected) |
| evtPulse | input | 4 | Event strobes for causes 1..4 |
| irqOut | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: five causes, a 32-bit data word and a 2-bit address. With these values every cause bit, the live level in bit 31 and the one unmapped address (3) can all be exercised. A behavioural model predicts `irqOut` and `rdData` on every clock. Directed sequences then cover a held core level across a clear, an event that collides with a clear, zero-data writes and writes to the unmapped address.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int REG_MASK = 0;
  localparam int REG_STAT = 1;
  localparam int REG_CLR  = 2;

  typedef struct packed {
    logic wrMask;
    logic wrSet;
    logic wrClr;
    logic rdMask;
    logic rdStat;
    logic rdNone;
  } regStrobe_t;
endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output regStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(REG_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(REG_CLR);

  always_comb begin
    strb        = '0;
    strb.wrMask = wrEn && (wrAddr == A_MASK);
    strb.wrSet  = wrEn && (wrAddr == A_STAT);
    strb.wrClr  = wrEn && (wrAddr == A_CLR);
    strb.rdMask = rdEn && (rdAddr == A_MASK);
    strb.rdStat = rdEn && (rdAddr == A_STAT);
    strb.rdNone = rdEn && (rdAddr != A_MASK) && (rdAddr != A_STAT);
  end

  AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.wrMask, strb.wrSet, strb.wrClr})) else $error("write strobes overlap"); // R10
  AST_RD_COVERS: assert property (@(posedge clk) disable iff (rst)
    rdEn |-> $onehot({strb.rdMask, strb.rdStat, strb.rdNone})) else $error("read decode gap"); // R10
endmodule

// File: rtl/irq_hub_datapath.sv
module irq_hub_datapath
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  regStrobe_t         strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               coreLevel,
  input  logic [NUM_SRC-1:1] evtPulse,
  output logic               irqOut,
  output logic [DATA_W-1:0]  rdData
);
  localparam int LIVE_BIT = DATA_W - 1;

  logic [NUM_SRC-1:0] maskReg;
  logic [NUM_SRC-1:0] statusReg;
  logic               corePrev;
  logic [NUM_SRC-1:0] hwSet;
  logic [NUM_SRC-1:0] setHit;
  logic [NUM_SRC-1:0] clrHit;
  logic [DATA_W-1:0]  statWord;
  logic [DATA_W-1:0]  maskWord;

  // Edge detect for the core level; other causes arrive as strobes.
  assign hwSet  = {evtPulse, coreLevel & ~corePrev};
  assign setHit = strb.wrSet ? wrData[NUM_SRC-1:0] : '0;
  assign clrHit = strb.wrClr ? wrData[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) corePrev <= 1'b0;
    else     corePrev <= coreLevel;
  end

  always_ff @(posedge clk) begin
    if (rst)              maskReg <= '0;
    else if (strb.wrMask) maskReg <= wrData[NUM_SRC-1:0];
  end

  // One sticky cell per cause; hardware event outranks a clear.
  for (genvar g = 0; g < NUM_SRC; g++) begin : gCell
    always_ff @(posedge clk) begin
      if (rst)            statusReg[g] <= 1'b0;
      else if (hwSet[g])  statusReg[g] <= 1'b1;
      else if (clrHit[g]) statusReg[g] <= 1'b0;
      else if (setHit[g]) statusReg[g] <= 1'b1;
    end
  end

  assign irqOut = |(statusReg & maskReg);

  always_comb begin
    statWord                = '0;
    statWord[NUM_SRC-1:0]   = statusReg;
    statWord[LIVE_BIT]      = coreLevel;
    maskWord                = '0;
    maskWord[NUM_SRC-1:0]   = maskReg;
  end

  always_ff @(posedge clk) begin
    if (rst)              rdData <= '0;
    else if (strb.rdMask) rdData <= maskWord;
    else if (strb.rdStat) rdData <= statWord;
    else if (strb.rdNone) rdData <= '0;
  end

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> (maskReg != '0)) else $error("irq with empty mask"); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    strb.wrClr |=> ((statusReg & $past(wrData[NUM_SRC-1:0] & ~hwSet)) == '0)) else $error("clear lost"); // R4
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    strb.wrSet |=> ((statusReg & $past(wrData[NUM_SRC-1:0])) == $past(wrData[NUM_SRC-1:0]))) else $error("set lost"); // R5
  AST_CORE_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(coreLevel) |-> ##1 statusReg[0]) else $error("core edge missed"); // R6
  AST_NO_SPONT: assert property (@(posedge clk) disable iff (rst)
    ((hwSet == '0) && !strb.wrSet) |=> ((statusReg & ~$past(statusReg)) == '0)) else $error("spurious set"); // R7
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    (hwSet != '0) |=> ((statusReg & $past(hwSet)) == $past(hwSet))) else $error("event lost"); // R8
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  input  logic               coreLevel,
  input  logic [NUM_SRC-1:1] evtPulse,
  output logic               irqOut
);
  regStrobe_t strb;

  irq_hub_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb)
  );

  irq_hub_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) uData (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData),
    .coreLevel(coreLevel), .evtPulse(evtPulse),
    .irqOut(irqOut), .rdData(rdData)
  );
endmodule

// File: tb/irq_hub_test.sv
`timescale 1ns/1ps
module irq_hub_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        wrEn = 0;
  logic [1:0]  wrAddr = 0;
  logic [31:0] wrData = 0;
  logic        rdEn = 0;
  logic [1:0]  rdAddr = 0;
  logic [31:0] rdData;
  logic        coreLevel = 0;
  logic [4:1]  evtPulse = 0;
  logic        irqOut;

  int nChk = 0, nFail = 0;
  bit done = 0;

  irq_hub uut (.*);

  always #10 clk = ~clk;

  // Behavioural reference model
  logic [4:0]  mMask, mStat;
  logic        mPrev;
  logic [31:0] mRd;

  always @(posedge clk) begin
    logic [4:0] hw, setV, clrV;
    if (rst) begin
      mMask = 0; mStat = 0; mPrev = 0; mRd = 0;
    end else begin
      hw = {evtPulse, (coreLevel && !mPrev)};
      if (rdEn) begin
        if (rdAddr == 0)      mRd = {27'd0, mMask};
        else if (rdAddr == 1) mRd = {coreLevel, 26'd0, mStat};
        else                  mRd = 0;
      end
      setV = (wrEn && wrAddr == 1) ? wrData[4:0] : 5'd0;
      clrV = (wrEn && wrAddr == 2) ? wrData[4:0] : 5'd0;
      for (int i = 0; i < 5; i++) begin
        if (hw[i])        mStat[i] = 1;
        else if (clrV[i]) mStat[i] = 0;
        else if (setV[i]) mStat[i] = 1;
      end
      if (wrEn && wrAddr == 0) mMask = wrData[4:0];
      mPrev = coreLevel;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irqOut == |(mStat & mMask), "R2 model irqOut", 32'(irqOut), 32'(|(mStat & mMask)));
      chk(rdData == mRd, "R10 model rdData", rdData, mRd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0; wrData = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    rdEn = 1; rdAddr = a;
    @(negedge clk);
    rdEn = 0;
    chk(rdData == exp, tag, rdData, exp);
  endtask

  task automatic pulse(input logic [4:1] v);
    evtPulse = v;
    @(negedge clk);
    evtPulse = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(irqOut == 0, "R1 irqOut after reset", 32'(irqOut), 0);
    chk(rdData == 0, "R1 rdData after reset", rdData, 0);
    rd(0, 0, "R1 mask reset");
    rd(1, 0, "R1 status reset");
    // mask register
    wr(0, 32'h1F);
    rd(0, 32'h1F, "R3 mask readback");
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h1F, "R3 mask upper bits zero");
    wr(0, 0);
    // event latching
    pulse(4'b0010);
    rd(1, 32'h4, "R7 hpd fall latched");
    chk(irqOut == 0, "R2 masked source", 32'(irqOut), 0);
    wr(0, 32'h4);
    chk(irqOut == 1, "R2 enabled source", 32'(irqOut), 1);
    wr(2, 0);
    rd(1, 32'h4, "R4 clear zero no effect");
    rd(2, 0, "R4 clear reads zero");
    wr(2, 32'h4);
    rd(1, 0, "R4 clear bit");
    chk(irqOut == 0, "R2 cleared irq", 32'(irqOut), 0);
    // software set
    wr(1, 32'h10);
    rd(1, 32'h10, "R5 software set");
    wr(1, 0);
    rd(1, 32'h10, "R5 zero write no effect");
    wr(2, 32'h10);
    // core edge and live level
    coreLevel = 1;
    @(negedge clk);
    @(negedge clk);
    rd(1, 32'h8000_0001, "R6 core rise latched");
    wr(2, 32'h1);
    @(negedge clk);
    rd(1, 32'h8000_0000, "R9 live level, R6 no retrigger");
    coreLevel = 0;
    @(negedge clk);
    rd(1, 0, "R9 live level low");
    coreLevel = 1;
    @(negedge clk);
    coreLevel = 0;
    rd(1, 32'h1, "R6 second rise");
    wr(2, 32'h1);
    // collision: event beats clear
    evtPulse = 4'b0100; wrEn = 1; wrAddr = 2; wrData = 32'h8;
    @(negedge clk);
    evtPulse = 0; wrEn = 0; wrData = 0;
    rd(1, 32'h8, "R8 event wins over clear");
    wr(2, 32'h8);
    // all hardware causes
    pulse(4'b1111);
    rd(1, 32'h1E, "R7 all events");
    wr(0, 32'h10);
    chk(irqOut == 1, "R2 error source enabled", 32'(irqOut), 1);
    // unmapped address
    wr(3, 32'h1F);
    rd(3, 0, "R10 unmapped reads zero");
    rd(0, 32'h10, "R10 unmapped write ignored");
    rd(1, 32'h1E, "R10 status untouched");
    @(negedge clk);
    chk(rdData == 32'h1E, "R10 rdData holds", rdData, 32'h1E);
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChk++; nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule